// File: doc/BRIEF.md
# Per-Thread Doorbell Status Register

This block keeps one doorbell-pending flag for each hardware thread of a multithreaded core. It presents those flags as a single core-level register that any thread can reach through one access port. The port carries the accessing thread's ID. A read gathers the flags into a vector indexed by thread ID. A write scatters the data bits back onto the flags. Data bits that do not map to a thread are dropped, and a one-cycle error event marks the write.

A mode input picks between two views. In shared mode every thread sees and changes the whole vector. With the mode input low, the register collapses to a one-thread register. In that view only bit 0 is meaningful, and bit 0 stands for the accessing thread's own flag.

Every access is first screened by a hypervisor facility gate. On a hypervisor-capable core, an access from outside hypervisor state while the facility-enable bit is clear is refused. A refused access changes no flag and returns zero. One cycle later it produces a one-cycle fault pulse, which carries a cause code and a request to clear the interrupt-cause field of the facility control register.

Top module: `dbell_status`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all pending flags read 0 and fault_o, cause_clr_o, wr_err_o and fault_cause_o are 0.
- R2: In shared mode (shared_mode=1), a permitted read returns bit N of rd_data equal to thread N's pending flag, in the same cycle. Bits at or above THREADS read 0, and rd_data is 0 whenever no permitted read is presented.
- R3: In shared mode, a permitted write loads pend_o with acc_wdata[THREADS-1:0] at the next clock edge.
- R4: In shared mode, a permitted write with any acc_wdata bit at index THREADS or above set pulses wr_err_o for exactly one cycle after the edge that takes the write. Those bits affect no flag.
- R5: In per-thread mode (shared_mode=0), a permitted read returns the accessing thread's flag (pend_o[acc_tid]) in bit 0 of rd_data, with all other bits 0.
- R6: In per-thread mode, a permitted write sets pend_o[acc_tid] to acc_wdata[0] at the next edge and leaves the other threads' flags unchanged. Any set bit 1 or above pulses wr_err_o for one cycle.
- R7: An access is refused when hv_capable=1, hv_state=0 and fac_enable=0. A refused access returns rd_data=0, changes no flag and raises no wr_err_o. After the next edge it gives a one-cycle fault_o pulse with cause_clr_o=1 and fault_cause_o equal to the CAUSE parameter. fault_cause_o is 0 whenever fault_o is low.
- R8: An access with hv_capable=0, with hv_state=1 or with fac_enable=1 is permitted and raises no fault.
- R9: A cycle with acc_valid=0 changes no flag and produces no fault or write error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shared_mode | input | 1 | 1: register spans all threads; 0: one-thread view |
| hv_capable | input | 1 | Core implements hypervisor state |
| hv_state | input | 1 | Accessor is in hypervisor state |
| fac_enable | input | 1 | Hypervisor facility-enable bit for this register |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1: write, 0: read |
| acc_tid | input | TID_W | Accessing thread ID |
| acc_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, combinational |
| pend_o | output | THREADS | Per-thread doorbell pending flags |
| fault_o | output | 1 | One-cycle facility-unavailable fault |
| fault_cause_o | output | 4 | Cause code during fault, else 0 |
| cause_clr_o | output | 1 | Clear request for the interrupt-cause field |
| wr_err_o | output | 1 | One-cycle invalid-write-bits event |

## Verification
The bench builds the block with its defaults: four threads, a two-bit thread ID and a 16-bit register. That leaves twelve invalid high data bits for the error path. Every thread ID is reachable, so the per-thread view can be shown to touch only the addressed flag while three neighbours hold their values. Random mixes of mode, gate inputs and write data also reach the corners where the two views interleave, where a refused write carries invalid bits, and where a write in one view is followed by a read in the other.

// File: rtl/dbell_pkg.sv
// Shared types for the doorbell status register.
// Assumes: nothing beyond the standard language.
package dbell_pkg;

    // Classification of the access presented in a cycle.
    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_READ    = 2'd1,
        ACC_WRITE   = 2'd2,
        ACC_REFUSED = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/dbell_gate.sv
// Facility gate: classifies an access as idle, read, write or refused.
// Assumes: gate inputs are stable for the whole access cycle.
module dbell_gate
    import dbell_pkg::*;
(
    input  logic      valid,
    input  logic      write,
    input  logic      hv_capable,
    input  logic      hv_state,
    input  logic      fac_enable,
    output acc_kind_e kind
);

    logic refuse;

    // Refuse only guest accesses on a hypervisor core with the facility off.
    always_comb begin
        refuse = hv_capable && !hv_state && !fac_enable;
        if (!valid)      kind = ACC_IDLE;
        else if (refuse) kind = ACC_REFUSED;
        else if (write)  kind = ACC_WRITE;
        else             kind = ACC_READ;
    end

endmodule

// File: rtl/dbell_wmask.sv
// Write decoder: turns write data into per-thread update enables and
// new values, and flags data bits that fall outside the visible width.
// Assumes: THREADS is a power of two, 1..8, and DATA_W > THREADS.
module dbell_wmask #(
    parameter int THREADS = 4,
    parameter int DATA_W  = 16,
    parameter int TID_W   = 2
) (
    input  logic               shared_mode,
    input  logic [TID_W-1:0]   tid,
    input  logic [DATA_W-1:0]  wdata,
    output logic [THREADS-1:0] upd,
    output logic [THREADS-1:0] nval,
    output logic               bad
);

    localparam logic [DATA_W-1:0] SHARED_MASK = DATA_W'((1 << THREADS) - 1);
    localparam logic [DATA_W-1:0] SINGLE_MASK = DATA_W'(1);

    logic [DATA_W-1:0] keep;

    // Choose the visible-bit mask from the mode; the rest is invalid.
    always_comb begin
        keep = shared_mode ? SHARED_MASK : SINGLE_MASK;
        bad  = |(wdata & ~keep);
    end

    // Per-thread enable and value: whole vector in shared mode, else own bit.
    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        if (THREADS == 1) begin : g_one
            always_comb begin
                upd[t]  = 1'b1;
                nval[t] = wdata[0];
            end
        end else begin : g_many
            always_comb begin
                upd[t]  = shared_mode || (tid == TID_W'(t));
                nval[t] = shared_mode ? wdata[t] : wdata[0];
            end
        end
    end

endmodule

// File: rtl/dbell_flags.sv
// Flag bank: one pending bit per thread, updated under per-bit enables.
// Assumes: synchronous active-low reset clears every flag.
module dbell_flags #(
    parameter int THREADS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [THREADS-1:0] upd,
    input  logic [THREADS-1:0] nval,
    output logic [THREADS-1:0] pend
);

    // Each flag loads its new value only when written and enabled.
    for (genvar t = 0; t < THREADS; t++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)              pend[t] <= 1'b0;
            else if (we && upd[t])   pend[t] <= nval[t];
        end
    end

endmodule

// File: rtl/dbell_status.sv
// Core-level doorbell status register: gathers per-thread pending flags
// on read, scatters write data onto them, and gates access through a
// hypervisor facility check that raises a one-cycle fault on refusal.
// Assumes: THREADS power of two in 1..8, DATA_W > THREADS; read data is
// combinational from the current flags, writes land at the next edge.
module dbell_status
    import dbell_pkg::*;
#(
    parameter int          THREADS = 4,
    parameter int          DATA_W  = 16,
    parameter logic [3:0]  CAUSE   = 4'h2,
    localparam int         TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shared_mode,
    input  logic               hv_capable,
    input  logic               hv_state,
    input  logic               fac_enable,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [TID_W-1:0]   acc_tid,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic [DATA_W-1:0]  rd_data,
    output logic [THREADS-1:0] pend_o,
    output logic               fault_o,
    output logic [3:0]         fault_cause_o,
    output logic               cause_clr_o,
    output logic               wr_err_o
);

    acc_kind_e          kind;
    logic [THREADS-1:0] upd;
    logic [THREADS-1:0] nval;
    logic               bad;
    logic               own_flag;

    dbell_gate u_gate (
        .valid      (acc_valid),
        .write      (acc_write),
        .hv_capable (hv_capable),
        .hv_state   (hv_state),
        .fac_enable (fac_enable),
        .kind       (kind)
    );

    dbell_wmask #(
        .THREADS (THREADS),
        .DATA_W  (DATA_W),
        .TID_W   (TID_W)
    ) u_wmask (
        .shared_mode (shared_mode),
        .tid         (acc_tid),
        .wdata       (acc_wdata),
        .upd         (upd),
        .nval        (nval),
        .bad         (bad)
    );

    dbell_flags #(
        .THREADS (THREADS)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (kind == ACC_WRITE),
        .upd   (upd),
        .nval  (nval),
        .pend  (pend_o)
    );

    // Pick the accessing thread's own flag for the one-thread view.
    if (THREADS == 1) begin : g_own1
        assign own_flag = pend_o[0];
    end else begin : g_ownn
        assign own_flag = pend_o[acc_tid];
    end

    // Assemble read data: whole vector when shared, own flag otherwise.
    always_comb begin
        rd_data = '0;
        if (kind == ACC_READ) begin
            if (shared_mode) rd_data[THREADS-1:0] = pend_o;
            else             rd_data[0] = own_flag;
        end
    end

    // Register the fault and error events as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_o       <= 1'b0;
            fault_cause_o <= 4'h0;
            cause_clr_o   <= 1'b0;
            wr_err_o      <= 1'b0;
        end else begin
            fault_o       <= (kind == ACC_REFUSED);
            fault_cause_o <= (kind == ACC_REFUSED) ? CAUSE : 4'h0;
            cause_clr_o   <= (kind == ACC_REFUSED);
            wr_err_o      <= (kind == ACC_WRITE) && bad;
        end
    end

endmodule

// File: rtl/dbell_status_chk.sv
// Checker for dbell_status: temporal properties over its ports.
// Assumes: reset is asserted at the first clock edge.
module dbell_status_chk #(
    parameter int          THREADS = 4,
    parameter int          DATA_W  = 16,
    parameter logic [3:0]  CAUSE   = 4'h2,
    parameter int          TID_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               shared_mode,
    input logic               hv_capable,
    input logic               hv_state,
    input logic               fac_enable,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [TID_W-1:0]   acc_tid,
    input logic [DATA_W-1:0]  acc_wdata,
    input logic [DATA_W-1:0]  rd_data,
    input logic [THREADS-1:0] pend_o,
    input logic               fault_o,
    input logic [3:0]         fault_cause_o,
    input logic               cause_clr_o,
    input logic               wr_err_o
);

    logic allowed;
    assign allowed = !(hv_capable && !hv_state && !fac_enable);

    // R1: reset leaves flags and pulses clear
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pend_o == '0) && !fault_o && !wr_err_o);

    // R2: upper bits always read zero, and nothing when no permitted read
    p_high_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data >> THREADS) == '0);
    p_no_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write && allowed) |-> rd_data == '0);

    // R3: shared write loads the flags
    p_shared_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && allowed && shared_mode
        |=> pend_o == $past(acc_wdata[THREADS-1:0]));

    // R4: error pulse lasts one cycle when the access stream goes idle
    p_err_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err_o && !acc_valid |=> !wr_err_o);

    // R5: one-thread view shows only bit 0
    p_single_view_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && !shared_mode |-> (rd_data >> 1) == '0);

    // R7: fault freezes flags, carries cause and clear, no write error
    p_fault_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> pend_o == $past(pend_o));
    p_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> cause_clr_o && fault_cause_o == CAUSE && !wr_err_o);
    p_cause_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_o |-> fault_cause_o == 4'h0 && !cause_clr_o);

    // R8: permitted access raises no fault
    p_no_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && allowed |=> !fault_o);

    // R9: idle cycle holds flags and raises nothing
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(pend_o) && !fault_o && !wr_err_o);

endmodule

bind dbell_status dbell_status_chk #(
    .THREADS (THREADS),
    .DATA_W  (DATA_W),
    .CAUSE   (CAUSE),
    .TID_W   (TID_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .shared_mode   (shared_mode),
    .hv_capable    (hv_capable),
    .hv_state      (hv_state),
    .fac_enable    (fac_enable),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_tid       (acc_tid),
    .acc_wdata     (acc_wdata),
    .rd_data       (rd_data),
    .pend_o        (pend_o),
    .fault_o       (fault_o),
    .fault_cause_o (fault_cause_o),
    .cause_clr_o   (cause_clr_o),
    .wr_err_o      (wr_err_o)
);

// File: tb/tb_dbell_status.sv
// Bench for dbell_status: behavioural reference model compared every clock.
module tb_dbell_status;

    localparam int T  = 4;
    localparam int DW = 16;
    localparam int TW = 2;
    localparam logic [3:0] CZ = 4'h2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          shared_mode, hv_capable, hv_state, fac_enable;
    logic          acc_valid, acc_write;
    logic [TW-1:0] acc_tid;
    logic [DW-1:0] acc_wdata;
    logic [DW-1:0] rd_data;
    logic [T-1:0]  pend_o;
    logic          fault_o, cause_clr_o, wr_err_o;
    logic [3:0]    fault_cause_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    bit m_pend [T];

    always #4 clk = ~clk;

    dbell_status #(.THREADS(T), .DATA_W(DW), .CAUSE(CZ)) dut (
        .clk(clk), .rst_n(rst_n), .shared_mode(shared_mode),
        .hv_capable(hv_capable), .hv_state(hv_state), .fac_enable(fac_enable),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_tid(acc_tid),
        .acc_wdata(acc_wdata), .rd_data(rd_data), .pend_o(pend_o),
        .fault_o(fault_o), .fault_cause_o(fault_cause_o),
        .cause_clr_o(cause_clr_o), .wr_err_o(wr_err_o)
    );

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int model_vec();
        int v = 0;
        for (int i = 0; i < T; i++) if (m_pend[i]) v += (1 << i);
        return v;
    endfunction

    // One access: inputs are already driven after a falling edge.
    task automatic run_cycle();
        bit blocked, exp_err, exp_fault;
        bit nxt [T];
        int exp_rd;
        string ptag;
        #1;
        blocked = hv_capable && !hv_state && !fac_enable;
        exp_rd = 0;
        if (acc_valid && !acc_write && !blocked) begin
            if (shared_mode) exp_rd = model_vec();
            else exp_rd = m_pend[int'(acc_tid)] ? 1 : 0;
        end
        chk(shared_mode ? "R2 read data" : "R5 read data", int'(rd_data), exp_rd);
        nxt = m_pend;
        exp_err = 0;
        exp_fault = acc_valid && blocked;
        ptag = "R2 flags after read";
        if (!acc_valid) ptag = "R9 flags after idle";
        else if (blocked) ptag = "R7 flags after refusal";
        else if (acc_write) begin
            if (shared_mode) begin
                ptag = "R3 flags after shared write";
                for (int i = 0; i < DW; i++) begin
                    if (i < T) nxt[i] = acc_wdata[i];
                    else if (acc_wdata[i]) exp_err = 1;
                end
            end else begin
                ptag = "R6 flags after per-thread write";
                nxt[int'(acc_tid)] = acc_wdata[0];
                for (int i = 1; i < DW; i++) if (acc_wdata[i]) exp_err = 1;
            end
        end
        @(posedge clk);
        #1;
        m_pend = nxt;
        chk(ptag, int'(pend_o), model_vec());
        chk(exp_fault ? "R7 fault" : "R8 no fault", int'(fault_o), int'(exp_fault));
        chk("R7 cause code", int'(fault_cause_o), exp_fault ? int'(CZ) : 0);
        chk("R7 cause clear", int'(cause_clr_o), int'(exp_fault));
        chk(shared_mode ? "R4 write error" : "R6 write error", int'(wr_err_o), int'(exp_err));
    endtask

    task automatic access(bit v, bit w, int tid, int data, bit sh, bit cap, bit hv, bit en);
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_tid = TW'(tid); acc_wdata = DW'(data);
        shared_mode = sh; hv_capable = cap; hv_state = hv; fac_enable = en;
        run_cycle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n = 0; acc_valid = 0; acc_write = 0; acc_tid = '0; acc_wdata = '0;
        shared_mode = 1; hv_capable = 1; hv_state = 0; fac_enable = 1;
        for (int i = 0; i < T; i++) m_pend[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 flags at reset", int'(pend_o), 0);
        chk("R1 fault at reset", int'(fault_o), 0);
        chk("R1 error at reset", int'(wr_err_o), 0);
        chk("R1 cause at reset", int'(fault_cause_o), 0);
        @(negedge clk);
        rst_n = 1;
        // R3 shared write then R2 read
        access(1, 1, 1, 'h000A, 1, 1, 0, 1);
        access(1, 0, 3, 0, 1, 1, 0, 1);
        // R4 invalid bits
        access(1, 1, 0, 'h8015, 1, 1, 0, 1);
        access(0, 0, 0, 0, 1, 1, 0, 1);
        // R5 / R6 per-thread view
        access(1, 0, 0, 0, 0, 1, 0, 1);
        access(1, 0, 2, 0, 0, 1, 0, 1);
        access(1, 1, 3, 'h0001, 0, 1, 0, 1);
        access(1, 1, 0, 'h0002, 0, 1, 0, 1);
        access(1, 0, 1, 0, 1, 1, 0, 1);
        // R7 refusal, R8 each permit path
        access(1, 1, 0, 'hFFFF, 1, 1, 0, 0);
        access(1, 0, 2, 0, 1, 1, 0, 0);
        access(1, 1, 2, 'h0004, 1, 0, 0, 0);
        access(1, 1, 2, 'h0000, 1, 1, 1, 0);
        access(1, 0, 2, 0, 0, 1, 1, 0);
        // R9 idle with gate closed
        access(0, 1, 1, 'hFFFF, 1, 1, 0, 0);
        // Random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom;
            access(r[0] | r[1], r[2], r[5:4], (r[3] ? $urandom : ($urandom & 'hF)),
                   r[6], r[7], r[8] & r[9], r[10] | r[11]);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule